// File: doc/BRIEF.md
# Quad Digital Potentiometer Serial Controller

This block is the digital side of a four-channel volatile digital potentiometer. A host talks to it as an SPI slave in mode 0: chip select is active low, data is sampled on the rising serial-clock edge, data out changes on the falling edge, and the most significant bit goes first. Each channel keeps a 7-bit wiper register that picks one of 128 taps. The channel drives a tap-select bus and a per-channel open flag. When the flag is high, the analog array disconnects the resistor end to end and ties the wiper to the low terminal.

The serial pins are first brought into the system clock domain. The controller then detects their edges and counts bits within the frame. A 16-bit command commits when chip select rises, but only if the frame is a whole multiple of 16 bits. Data out comes from the most significant bit of the receive shift register. That register is preloaded at frame start with a pending read response, or with zeros. As a result, bits that enter at data in reappear at data out 16 clocks later. Several parts can therefore share one chip select and sit in a daisy chain. The first command sent ends up in the part furthest down the chain.

Top module: `dpot_spi_ctrl`

## Requirements
- R1: After reset, every wiper register holds 64, every channel's open flag is low, and data out is low.
- R2: A frame with bits [15:14]=01 (write) loads bits [6:0] into the wiper register selected by bits [13:12]. The tap-select field of that channel (bits [7c+6:7c] of the tap bus) shows the new value, and the other channels keep theirs.
- R3: A frame with bits [15:14]=10 (read) makes the next frame shift out a response word MSB first. With bit 11 clear, the response is the wiper register selected by bits [13:12] in bits [6:0], with bits [15:7] zero. With bit 11 set, the response is the 4-bit shutdown mask in bits [3:0], with the rest zero.
- R4: A frame with bits [15:14]=11 loads bits [3:0] into the shutdown mask (bit c for channel c). A channel with its mask bit set drives tap-select 0 and its open flag high. Its stored wiper value is kept, and the channel returns to that value when the bit is cleared.
- R5: While chip select is high, activity on the serial clock and data in changes no register, and data out stays low.
- R6: A frame commits only when chip select rises after a nonzero multiple of 16 rising clock edges. Frames of 15 or 17 bits are discarded. In a 32-bit frame, only the last 16 bits form the command.
- R7: When no read is pending, data out is low for the first 16 bits of a frame. After that it repeats the bits received 16 clocks earlier.
- R8: In a two-part chain, with one part's data out feeding the next part's data in, a 32-bit frame delivers its first 16 bits to the far part and its last 16 bits to the near part. A 32-bit response frame returns the far part's response first, then the near part's.
- R9: A frame with bits [15:14]=00 (no-op) changes no register, whatever its other bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the serial pins are oversampled on it |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Serial chip select, active low |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_sdi | input | 1 | Serial data in |
| spi_sdo | output | 1 | Serial data out, low while deselected |
| tap_sel | output | NCH*TAP_W (28) | Tap select for each channel, channel c in bits [7c+6:7c] |
| chan_open | output | NCH (4) | Per-channel shutdown qualifier: resistor open, wiper to low end |

## Verification
The bench builds two copies with the default parameters: four channels, 7-bit taps, 16-bit frames and a two-stage input synchronizer. One copy's data out is wired into the other's data in, so the chain case is always present. Because the tap field is only 7 bits wide, the bench can sweep all 128 wiper values, rotating them across the channels. Each value is written and then read back through the response frame. Around that sweep it covers shutdown entry and exit, status read-back, frames of 15, 17 and 32 bits, deselected clock activity, and a write-then-read over the two-part chain.

// File: rtl/dpot_pkg.sv
// Shared definitions for the quad potentiometer controller.
// Assumes the operation code sits in the two top bits of a frame.
package dpot_pkg;
    typedef enum logic [1:0] {
        OP_NOP   = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_SHDN  = 2'b11
    } dpot_op_e;
endpackage

// File: rtl/dpot_sync.sv
// Multi-stage synchronizer for a small vector of asynchronous pins.
// Assumes STAGES >= 1; all bits see the same latency, so that data and
// clock pins stay aligned to each other.
module dpot_sync #(
    parameter int              W       = 3,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage: capture raw pins
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= d_i;
            end
        end else begin : g_next
            // Later stages: settle the previous stage
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/dpot_shifter.sv
// Serial front end: detects edges of the synchronized serial clock and
// chip select, shifts data in on rising edges (MSB first), drives data
// out on falling edges, counts bits modulo the frame length and flags a
// commit when chip select rises on a frame boundary.
// Assumes its inputs are already in the clk domain.
module dpot_shifter #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_s,
    input  logic               cs_s,
    input  logic               sdi_s,
    input  logic [FRAME_W-1:0] load_word_i,
    output logic [FRAME_W-1:0] sr_o,
    output logic               sdo_o,
    output logic               cs_fall_o,
    output logic               commit_o
);
    localparam int CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);

    logic             sclk_q, cs_q;
    logic             sclk_rise, sclk_fall, cs_rise;
    logic [CNT_W-1:0] cnt_q;
    logic             seen_q;
    logic [FRAME_W-1:0] sr_q;
    logic             sdo_q;

    assign sclk_rise = sclk_s & ~sclk_q & ~cs_s;
    assign sclk_fall = ~sclk_s & sclk_q & ~cs_s;
    assign cs_fall_o = ~cs_s & cs_q;
    assign cs_rise   = cs_s & ~cs_q;

    // Previous values of the synchronized pins, for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
        end else begin
            sclk_q <= sclk_s;
            cs_q   <= cs_s;
        end
    end

    // Bit counter modulo frame length plus a flag that any bit arrived
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else if (cs_fall_o) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else if (sclk_rise) begin
            cnt_q  <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
            seen_q <= 1'b1;
        end
    end

    // Shift register: preload at frame start, shift in on rising edges
    always_ff @(posedge clk) begin
        if (!rst_n)         sr_q <= '0;
        else if (cs_fall_o) sr_q <= load_word_i;
        else if (sclk_rise) sr_q <= {sr_q[FRAME_W-2:0], sdi_s};
    end

    // Data out: first bit at selection, next bits on falling edges
    always_ff @(posedge clk) begin
        if (!rst_n)         sdo_q <= 1'b0;
        else if (cs_fall_o) sdo_q <= load_word_i[FRAME_W-1];
        else if (cs_rise)   sdo_q <= 1'b0;
        else if (sclk_fall) sdo_q <= sr_q[FRAME_W-1];
    end

    assign commit_o = cs_rise & seen_q & (cnt_q == '0);
    assign sr_o     = sr_q;
    assign sdo_o    = sdo_q;
endmodule

// File: rtl/dpot_regfile.sv
// Register file and command decoder: per-channel wiper registers preset
// to mid-scale, a shutdown mask, and a pending-read tracker that
// builds the response word for the next frame.
// Assumes NCH >= 2, NCH <= TAP_W, and a frame wide enough for
// op(2) + index + status bit + at least one spare bit + data.
module dpot_regfile
    import dpot_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int TAP_W   = 7,
    parameter int FRAME_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   commit_i,
    input  logic                   cs_fall_i,
    input  logic [FRAME_W-1:0]     frame_i,
    output logic [NCH*TAP_W-1:0]   wiper_o,
    output logic [NCH-1:0]         sd_mask_o,
    output logic [FRAME_W-1:0]     resp_o
);
    localparam int IDX_W    = $clog2(NCH);
    localparam int IDX_HI   = FRAME_W - 3;
    localparam int STAT_BIT = FRAME_W - 3 - IDX_W;
    localparam logic [TAP_W-1:0] MID = {1'b1, {(TAP_W-1){1'b0}}};

    dpot_op_e         op;
    logic [IDX_W-1:0] idx;
    logic             stat_sel;
    logic [TAP_W-1:0] data;
    logic             unused_spare;

    assign op           = dpot_op_e'(frame_i[FRAME_W-1 -: 2]);
    assign idx          = frame_i[IDX_HI -: IDX_W];
    assign stat_sel     = frame_i[STAT_BIT];
    assign data         = frame_i[TAP_W-1:0];
    assign unused_spare = ^frame_i[STAT_BIT-1:TAP_W];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [TAP_W-1:0] wiper_q;
        // Wiper register: mid-scale at reset, load on an addressed write
        always_ff @(posedge clk) begin
            if (!rst_n)
                wiper_q <= MID;
            else if (commit_i && op == OP_WRITE && idx == IDX_W'(g))
                wiper_q <= data;
        end
        assign wiper_o[g*TAP_W +: TAP_W] = wiper_q;
    end

    logic [NCH-1:0]   sd_mask_q;
    logic             pend_q, pend_stat_q;
    logic [IDX_W-1:0] pend_idx_q;

    // Shutdown mask: loaded whole by a shutdown-control command
    always_ff @(posedge clk) begin
        if (!rst_n)                          sd_mask_q <= '0;
        else if (commit_i && op == OP_SHDN)  sd_mask_q <= data[NCH-1:0];
    end

    // Pending read: set by a read command, consumed at next frame start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            pend_stat_q <= 1'b0;
            pend_idx_q  <= '0;
        end else if (commit_i && op == OP_READ) begin
            pend_q      <= 1'b1;
            pend_stat_q <= stat_sel;
            pend_idx_q  <= idx;
        end else if (cs_fall_i) begin
            pend_q      <= 1'b0;
        end
    end

    // Response word offered to the shifter for preload
    always_comb begin
        resp_o = '0;
        if (pend_q) begin
            if (pend_stat_q) resp_o[NCH-1:0]   = sd_mask_q;
            else             resp_o[TAP_W-1:0] = wiper_o[pend_idx_q*TAP_W +: TAP_W];
        end
    end

    assign sd_mask_o = sd_mask_q;
endmodule

// File: rtl/dpot_spi_ctrl.sv
// Top of the quad potentiometer controller: synchronizes the serial pins,
// runs the shifter and register file, and forms the per-channel tap
// outputs, forcing tap 0 on channels in shutdown.
// Assumes clk runs at least about eight times faster than the serial clock.
module dpot_spi_ctrl #(
    parameter int NCH         = 4,
    parameter int TAP_W       = 7,
    parameter int FRAME_W     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 spi_cs_n,
    input  logic                 spi_sclk,
    input  logic                 spi_sdi,
    output logic                 spi_sdo,
    output logic [NCH*TAP_W-1:0] tap_sel,
    output logic [NCH-1:0]       chan_open
);
    logic [2:0]           pins_s;
    logic                 cs_s, sclk_s, sdi_s;
    logic [FRAME_W-1:0]   sr_q;
    logic [FRAME_W-1:0]   resp_word;
    logic                 cs_fall;
    logic                 frame_commit;
    logic [NCH*TAP_W-1:0] wiper_flat;
    logic [NCH-1:0]       sd_mask;

    dpot_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({spi_cs_n, spi_sclk, spi_sdi}),
        .q_o   (pins_s)
    );
    assign {cs_s, sclk_s, sdi_s} = pins_s;

    dpot_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_s      (sclk_s),
        .cs_s        (cs_s),
        .sdi_s       (sdi_s),
        .load_word_i (resp_word),
        .sr_o        (sr_q),
        .sdo_o       (spi_sdo),
        .cs_fall_o   (cs_fall),
        .commit_o    (frame_commit)
    );

    dpot_regfile #(.NCH(NCH), .TAP_W(TAP_W), .FRAME_W(FRAME_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit_i  (frame_commit),
        .cs_fall_i (cs_fall),
        .frame_i   (sr_q),
        .wiper_o   (wiper_flat),
        .sd_mask_o (sd_mask),
        .resp_o    (resp_word)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_tap
        // Tap output: stored wiper, or the low end while shut down
        assign tap_sel[g*TAP_W +: TAP_W] = sd_mask[g] ? '0 : wiper_flat[g*TAP_W +: TAP_W];
    end
    assign chan_open = sd_mask;
endmodule

// File: rtl/dpot_spi_ctrl_chk.sv
// Property checker for the quad potentiometer controller, bound to the top.
module dpot_spi_ctrl_chk #(
    parameter int NCH     = 4,
    parameter int TAP_W   = 7,
    parameter int FRAME_W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cs_s,
    input logic                 sdo,
    input logic [FRAME_W-1:0]   sr,
    input logic                 commit,
    input logic [NCH*TAP_W-1:0] wipers,
    input logic [NCH-1:0]       sd_mask
);
    localparam logic [TAP_W-1:0] MID = {1'b1, {(TAP_W-1){1'b0}}};

    // R1: first cycle out of reset shows mid-scale wipers and no shutdown
    a_r1_reset_mid: assert property (@(posedge clk)
        (rst_n && $past(!rst_n)) |-> (wipers == {NCH{MID}} && sd_mask == '0));

    // R5: while deselected the shift register holds and data out is low
    a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && $past(cs_s)) |-> ($stable(sr) && !sdo));

    // R6: no register changes without a committed frame
    a_r6_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(wipers) && $stable(sd_mask)));

    // R4: a shutdown mask change leaves the stored wiper values alone
    a_r4_shdn_keeps_wiper: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_mask != $past(sd_mask)) |-> $stable(wipers));
endmodule

bind dpot_spi_ctrl dpot_spi_ctrl_chk #(
    .NCH(NCH), .TAP_W(TAP_W), .FRAME_W(FRAME_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_s    (cs_s),
    .sdo     (spi_sdo),
    .sr      (sr_q),
    .commit  (frame_commit),
    .wipers  (wiper_flat),
    .sd_mask (sd_mask)
);

// File: tb/dpot_spi_ctrl_tb.sv
`timescale 1ns/1ps
module dpot_spi_ctrl_tb;
    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic        a_sdo, b_sdo;
    logic [27:0] taps_a, taps_b;
    logic [3:0]  open_a, open_b;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    logic [6:0] m [4];

    always #4 clk = ~clk;

    dpot_spi_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk),
        .spi_sdi(sdi), .spi_sdo(a_sdo), .tap_sel(taps_a), .chan_open(open_a));

    dpot_spi_ctrl u_dut_b (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk),
        .spi_sdi(a_sdo), .spi_sdo(b_sdo), .tap_sel(taps_b), .chan_open(open_b));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] frm(input logic [1:0] op, input logic [1:0] idx,
                                        input logic st, input logic [6:0] d);
        return {op, idx, st, 4'b0000, d};
    endfunction

    function automatic logic [27:0] exp_taps(input logic [3:0] mask);
        logic [27:0] t;
        for (int c = 0; c < 4; c++) t[c*7 +: 7] = mask[c] ? 7'd0 : m[c];
        return t;
    endfunction

    task automatic xfer(input int nb, input logic [63:0] w, input bit from_b,
                        output logic [63:0] got);
        got = '0;
        @(negedge clk) cs_n = 1'b0;
        for (int i = nb - 1; i >= 0; i--) begin
            sdi = w[i];
            repeat (HALF) @(negedge clk);
            got = {got[62:0], (from_b ? b_sdo : a_sdo)};
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
        sdi = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [63:0] r;
        for (int c = 0; c < 4; c++) m[c] = 7'd64;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: reset state
        chk("R1 taps", taps_a, exp_taps(4'h0));
        chk("R1 open", open_a, 4'h0);
        chk("R1 sdo", a_sdo, 1'b0);

        // R2/R3: every tap value, rotating channels, written then read back
        for (int v = 0; v < 128; v++) begin
            logic [1:0] ch;
            ch = 2'(v % 4);
            xfer(16, frm(2'b01, ch, 1'b0, 7'(v)), 1'b0, r);
            m[ch] = 7'(v);
            chk("R2 write", taps_a, exp_taps(4'h0));
            xfer(16, frm(2'b10, ch, 1'b0, 7'h00), 1'b0, r);
            xfer(16, 16'h0000, 1'b0, r);
            chk("R3 read", r[15:0], {9'd0, 7'(v)});
        end

        // R9: no-op with busy other bits changes nothing
        xfer(16, 16'h3FFF, 1'b0, r);
        chk("R9 nop", taps_a, exp_taps(4'h0));

        // R4: shutdown channels 0 and 2
        xfer(16, frm(2'b11, 2'd0, 1'b0, 7'h05), 1'b0, r);
        chk("R4 taps shut", taps_a, exp_taps(4'h5));
        chk("R4 open", open_a, 4'h5);
        xfer(16, frm(2'b10, 2'd0, 1'b1, 7'h00), 1'b0, r);
        xfer(16, 16'h0000, 1'b0, r);
        chk("R3 status read", r[15:0], 16'h0005);
        xfer(16, frm(2'b10, 2'd2, 1'b0, 7'h00), 1'b0, r);
        xfer(16, 16'h0000, 1'b0, r);
        chk("R4 kept value", r[15:0], {9'd0, m[2]});
        xfer(16, frm(2'b11, 2'd0, 1'b0, 7'h00), 1'b0, r);
        chk("R4 restored", taps_a, exp_taps(4'h0));
        chk("R4 open clear", open_a, 4'h0);

        // R6: wrong-length frames are dropped
        xfer(15, {49'd0, frm(2'b01, 2'd1, 1'b0, 7'd3) >> 1}, 1'b0, r);
        chk("R6 15-bit", taps_a, exp_taps(4'h0));
        xfer(17, {47'd0, 1'b0, frm(2'b01, 2'd1, 1'b0, 7'd3)}, 1'b0, r);
        chk("R6 17-bit", taps_a, exp_taps(4'h0));

        // R6/R7: 32-bit frame, last half commits, first half passes through
        xfer(32, {32'd0, 16'h0A5A, frm(2'b01, 2'd1, 1'b0, 7'd3)}, 1'b0, r);
        m[1] = 7'd3;
        chk("R6 32-bit commit", taps_a, exp_taps(4'h0));
        chk("R7 pass-through", r[31:0], {16'h0000, 16'h0A5A});

        // R5: deselected clock and data activity
        for (int k = 0; k < 20; k++) begin
            @(negedge clk) sdi = k[0] ^ k[2];
            repeat (HALF) @(negedge clk) sclk = 1'b1;
            repeat (HALF) @(negedge clk) sclk = 1'b0;
        end
        repeat (4) @(negedge clk);
        chk("R5 taps held", taps_a, exp_taps(4'h0));
        chk("R5 sdo low", a_sdo, 1'b0);

        // R8: two-part chain write then read
        xfer(32, {32'd0, frm(2'b01, 2'd1, 1'b0, 7'd99), frm(2'b01, 2'd2, 1'b0, 7'd5)}, 1'b0, r);
        m[2] = 7'd5;
        chk("R8 near part", taps_a, exp_taps(4'h0));
        chk("R8 far part", taps_b, {7'd64, 7'd64, 7'd99, 7'd64});
        xfer(32, {32'd0, frm(2'b10, 2'd1, 1'b0, 7'd0), frm(2'b10, 2'd2, 1'b0, 7'd0)}, 1'b0, r);
        xfer(32, 64'd0, 1'b1, r);
        chk("R8 chain read", r[31:0], {16'd99, 16'd5});

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule